// File: doc/BRIEF.md
# Slot-Gated E1 Test Pattern Generator and Checker

This block drives a 2^15−1 pseudo-random test sequence into the transmit bit stream of an E1 channel and checks that same sequence in the receive stream. The framer supplies a bit strobe and the current time-slot number. A two-bit mode input chooses where the pattern is placed: over the whole frame, over every slot except slot 0, in one slot picked by a slot-select input, or nowhere. Bits outside the chosen slots pass straight from the transmit input to the transmit output.

The receive side synchronises itself to the incoming stream. It loads its register from received bits, confirms alignment over a run of error-free compares, and then counts mismatches until the error density shows that alignment is gone. After that it starts over. The error count is read through a one-cycle strobe. The strobe copies the running count to an output register and starts a new count. The count saturates instead of wrapping.

The transmit and receive sides use the same slot gating. A line looped back in phase therefore locks without any other setup.

Top module: `prbs_slot_engine`

## Requirements
- R1: With mode 2'b00 every bit of every slot (0 to 31) carries the pattern. The pattern bit is the inverse of s[14]^s[13] of a 15-bit register s, which is all ones after reset and shifts left with s[14]^s[13] entering bit 0 on each advance.
- R2: With mode 2'b01, slot 0 copies tx_in to tx_out and slots 1 to 31 carry the pattern.
- R3: With mode 2'b10 only the slot equal to sel_slot carries the pattern; every other slot copies tx_in.
- R4: With mode 2'b11, tx_out equals tx_in in every slot, and neither the generator nor the checker advances.
- R5: The generator advances only on a cycle with bit_en high inside a pattern slot. The sequence therefore continues unbroken across frames, mode changes and stalls, and tx_out holds while bit_en is low.
- R6: The checker fills its register from 15 received pattern bits, then needs 32 consecutive matching compares. In an error-free stream, locked goes high at the clock edge of the 47th pattern bit after reset.
- R7: While locked, each received pattern bit that differs from the prediction adds one to the running count. A one-cycle err_rd pulse copies the running count to err_cnt, which is visible on the next cycle, and restarts the count. err_cnt changes at no other time.
- R8: Once locked, received bits are judged in windows of 64 pattern bits, the first window starting on the bit after lock. The 6th mismatch in a window clears locked. Five mismatches leave it set.
- R9: A mismatch while the checker is not yet locked restarts the 15-bit fill, and it is not counted.
- R10: The running count saturates at all ones (2^CNT_W−1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Strobe marking a valid bit position this cycle |
| slot_idx | input | SLOT_W | Current time-slot number from the framer |
| mode | input | 2 | Placement: 00 whole frame, 01 slots 1-31, 10 one slot, 11 off |
| sel_slot | input | SLOT_W | Slot used in one-slot mode |
| tx_in | input | 1 | Transmit data from upstream |
| tx_out | output | 1 | Transmit data with pattern inserted |
| rx_in | input | 1 | Receive data to check |
| err_rd | input | 1 | Read-and-clear strobe for the error count |
| err_cnt | output | CNT_W | Latched error count |
| locked | output | 1 | Checker aligned to the received pattern |

## Verification
The bench targets the exact lock edge, both in a clean stream and after one error during acquisition. A checker that miscounts its fill or its run, or that keeps its partial run after the error, locks a bit early or late. The bench injects five and then six errors inside one 64-bit window, so an off-by-one threshold, or a window that starts on the wrong bit, shows up as lock held or lost at the wrong point. It checks that the transmit pattern continues across off-mode segments and bit_en stalls; a generator that advanced on masked or stalled bits would shift the whole later sequence. A second instance with a 4-bit counter is driven into saturation; a wrapping counter reads back 4 there instead of 15.

// File: rtl/prbs_e1_pkg.sv
package prbs_e1_pkg;

   // placement codes presented on the mode input
   typedef enum logic [1:0] {
      PM_WHOLE   = 2'b00,
      PM_NOSLOT0 = 2'b01,
      PM_ONESLOT = 2'b10,
      PM_OFF     = 2'b11
   } pmode_e;

   // receive alignment states
   typedef enum logic [1:0] {
      CK_FILL  = 2'b00,
      CK_PROVE = 2'b01,
      CK_HOLD  = 2'b10
   } ckst_e;

endpackage

// File: rtl/prbs_slot_gate.sv
module prbs_slot_gate
   import prbs_e1_pkg::*;
#(
   parameter int SLOT_W = 5
) (
   input  logic [1:0]        mode,
   input  logic [SLOT_W-1:0] slot_idx,
   input  logic [SLOT_W-1:0] sel_slot,
   output logic              active
);

   always_comb begin
      unique case (pmode_e'(mode))
         PM_WHOLE:   active = 1'b1;
         PM_NOSLOT0: active = (slot_idx != '0);
         PM_ONESLOT: active = (slot_idx == sel_slot);
         default:    active = 1'b0;
      endcase
   end

endmodule

// File: rtl/prbs_pat_gen.sv
module prbs_pat_gen #(
   parameter int LFSR_W = 15,
   parameter int TAP_A  = 15,
   parameter int TAP_B  = 14,
   parameter bit INVERT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   output logic pat_bit
);

   logic [LFSR_W-1:0] sreg;
   logic              fb;

   assign fb = sreg[TAP_A-1] ^ sreg[TAP_B-1];

   always_ff @(posedge clk) begin
      if (!rst_n)   sreg <= '1;
      else if (adv) sreg <= {sreg[LFSR_W-2:0], fb};
   end

   generate
      if (INVERT) begin : g_inv
         assign pat_bit = ~fb;
      end else begin : g_true
         assign pat_bit = fb;
      end
   endgenerate

endmodule

// File: rtl/prbs_pat_chk.sv
module prbs_pat_chk
   import prbs_e1_pkg::*;
#(
   parameter int LFSR_W      = 15,
   parameter int TAP_A       = 15,
   parameter int TAP_B       = 14,
   parameter bit INVERT      = 1'b1,
   parameter int LOCK_RUN    = 32,
   parameter int WIN_LEN     = 64,
   parameter int WIN_ERR_MAX = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic chk_en,
   input  logic rx_bit,
   output logic locked,
   output logic err_pulse
);

   localparam int FILL_CW = $clog2(LFSR_W);
   localparam int RUN_W   = $clog2(LOCK_RUN);
   localparam int WIN_W   = $clog2(WIN_LEN);
   localparam int WE_W    = $clog2(WIN_ERR_MAX + 1);
   localparam logic [FILL_CW-1:0] FILL_LAST = FILL_CW'(LFSR_W - 1);
   localparam logic [RUN_W-1:0]   RUN_LAST  = RUN_W'(LOCK_RUN - 1);
   localparam logic [WIN_W-1:0]   WIN_LAST  = WIN_W'(WIN_LEN - 1);
   localparam logic [WE_W-1:0]    WE_LIMIT  = WE_W'(WIN_ERR_MAX);

   ckst_e             st;
   logic [LFSR_W-1:0] sreg;
   logic [FILL_CW-1:0] fill_cnt;
   logic [RUN_W-1:0]  run_cnt;
   logic [WIN_W-1:0]  win_cnt;
   logic [WE_W-1:0]   win_err;
   logic [WE_W-1:0]   win_err_nxt;
   logic              rx_raw;
   logic              pred;
   logic              mism;

   generate
      if (INVERT) begin : g_inv
         assign rx_raw = ~rx_bit;
      end else begin : g_true
         assign rx_raw = rx_bit;
      end
   endgenerate

   assign pred        = sreg[TAP_A-1] ^ sreg[TAP_B-1];
   assign mism        = (rx_raw != pred);
   assign win_err_nxt = win_err + WE_W'(mism);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= CK_FILL;
         sreg     <= '0;
         fill_cnt <= '0;
         run_cnt  <= '0;
         win_cnt  <= '0;
         win_err  <= '0;
      end else if (chk_en) begin
         unique case (st)
            CK_FILL: begin
               sreg <= {sreg[LFSR_W-2:0], rx_raw};
               if (fill_cnt == FILL_LAST) begin
                  fill_cnt <= '0;
                  run_cnt  <= '0;
                  st       <= CK_PROVE;
               end else begin
                  fill_cnt <= fill_cnt + 1'b1;
               end
            end
            CK_PROVE: begin
               if (mism) begin
                  fill_cnt <= '0;
                  st       <= CK_FILL;
               end else begin
                  sreg <= {sreg[LFSR_W-2:0], pred};
                  if (run_cnt == RUN_LAST) begin
                     win_cnt <= '0;
                     win_err <= '0;
                     st      <= CK_HOLD;
                  end else begin
                     run_cnt <= run_cnt + 1'b1;
                  end
               end
            end
            default: begin
               sreg <= {sreg[LFSR_W-2:0], pred};
               if (win_err_nxt == WE_LIMIT) begin
                  fill_cnt <= '0;
                  st       <= CK_FILL;
               end else if (win_cnt == WIN_LAST) begin
                  win_cnt <= '0;
                  win_err <= '0;
               end else begin
                  win_cnt <= win_cnt + 1'b1;
                  win_err <= win_err_nxt;
               end
            end
         endcase
      end
   end

   assign locked    = (st == CK_HOLD);
   assign err_pulse = locked && chk_en && mism;

endmodule

// File: rtl/prbs_err_tally.sv
module prbs_err_tally #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             rd,
   output logic [CNT_W-1:0] cnt_q
);

   logic [CNT_W-1:0] run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run   <= '0;
         cnt_q <= '0;
      end else if (rd) begin
         cnt_q <= run;
         run   <= CNT_W'(inc);
      end else if (inc && (run != '1)) begin
         run <= run + 1'b1;
      end
   end

endmodule

// File: rtl/prbs_slot_engine.sv
module prbs_slot_engine #(
   parameter int SLOT_W      = 5,
   parameter int LFSR_W      = 15,
   parameter int TAP_A       = 15,
   parameter int TAP_B       = 14,
   parameter bit INVERT      = 1'b1,
   parameter int LOCK_RUN    = 32,
   parameter int WIN_LEN     = 64,
   parameter int WIN_ERR_MAX = 6,
   parameter int CNT_W       = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic [SLOT_W-1:0] slot_idx,
   input  logic [1:0]        mode,
   input  logic [SLOT_W-1:0] sel_slot,
   input  logic              tx_in,
   output logic              tx_out,
   input  logic              rx_in,
   input  logic              err_rd,
   output logic [CNT_W-1:0]  err_cnt,
   output logic              locked
);

   generate
      if (TAP_A != LFSR_W) begin : g_bad_tap_a
         $error("TAP_A must equal LFSR_W");
      end
      if (TAP_B >= TAP_A || TAP_B < 1) begin : g_bad_tap_b
         $error("TAP_B must lie in 1..TAP_A-1");
      end
      if (LOCK_RUN < 2 || WIN_LEN < 2 || (WIN_LEN & (WIN_LEN - 1)) != 0) begin : g_bad_win
         $error("LOCK_RUN >= 2 and WIN_LEN a power of two >= 2 required");
      end
      if (WIN_ERR_MAX < 1 || WIN_ERR_MAX > WIN_LEN) begin : g_bad_thr
         $error("WIN_ERR_MAX must lie in 1..WIN_LEN");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
   endgenerate

   logic active;
   logic step;
   logic pat_bit;
   logic err_pulse;

   prbs_slot_gate #(.SLOT_W(SLOT_W)) u_gate (
      .mode     (mode),
      .slot_idx (slot_idx),
      .sel_slot (sel_slot),
      .active   (active)
   );

   assign step = bit_en & active;

   prbs_pat_gen #(
      .LFSR_W (LFSR_W), .TAP_A (TAP_A), .TAP_B (TAP_B), .INVERT (INVERT)
   ) u_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (step),
      .pat_bit (pat_bit)
   );

   assign tx_out = active ? pat_bit : tx_in;

   prbs_pat_chk #(
      .LFSR_W (LFSR_W), .TAP_A (TAP_A), .TAP_B (TAP_B), .INVERT (INVERT),
      .LOCK_RUN (LOCK_RUN), .WIN_LEN (WIN_LEN), .WIN_ERR_MAX (WIN_ERR_MAX)
   ) u_chk (
      .clk       (clk),
      .rst_n     (rst_n),
      .chk_en    (step),
      .rx_bit    (rx_in),
      .locked    (locked),
      .err_pulse (err_pulse)
   );

   prbs_err_tally #(.CNT_W(CNT_W)) u_tally (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (err_pulse),
      .rd    (err_rd),
      .cnt_q (err_cnt)
   );

endmodule

// File: rtl/prbs_slot_engine_chk.sv
module prbs_slot_engine_chk #(
   parameter int SLOT_W = 5,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bit_en,
   input logic [SLOT_W-1:0] slot_idx,
   input logic [1:0]        mode,
   input logic              tx_in,
   input logic              tx_out,
   input logic              err_rd,
   input logic [CNT_W-1:0]  err_cnt,
   input logic              locked
);

   // R4
   off_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11) |-> (tx_out == tx_in));

   // R2
   slot0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && slot_idx == '0) |-> (tx_out == tx_in));

   // R7
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(err_cnt) |-> $past(err_rd));

   // R6
   lock_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(locked) |-> $past(bit_en));

   // R4
   off_nolock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> ($past(mode) != 2'b11));

endmodule

bind prbs_slot_engine prbs_slot_engine_chk #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_prop (
   .clk      (clk),
   .rst_n    (rst_n),
   .bit_en   (bit_en),
   .slot_idx (slot_idx),
   .mode     (mode),
   .tx_in    (tx_in),
   .tx_out   (tx_out),
   .err_rd   (err_rd),
   .err_cnt  (err_cnt),
   .locked   (locked)
);

// File: tb/tb_prbs_slot_engine.sv
module tb_prbs_slot_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_en = 1'b0;
   logic [4:0]  slot_idx = '0;
   logic [1:0]  mode = 2'b00;
   logic [4:0]  sel_slot = '0;
   logic        tx_in = 1'b0;
   logic        flip = 1'b0;
   logic        err_rd = 1'b0;
   logic        tx_out, tx_out_s;
   logic        rx_in, rx_in_s;
   logic [15:0] err_cnt;
   logic [3:0]  err_cnt_s;
   logic        locked, locked_s;

   int n_chk = 0;
   int n_bad = 0;
   int seg_bad;
   bit done = 1'b0;

   logic [14:0] g;
   logic [4:0]  cur_slot;
   logic [2:0]  cur_bit;

   always #10 clk = ~clk;

   assign rx_in   = tx_out ^ flip;
   assign rx_in_s = tx_out_s ^ flip;

   prbs_slot_engine dut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .slot_idx(slot_idx),
      .mode(mode), .sel_slot(sel_slot), .tx_in(tx_in), .tx_out(tx_out),
      .rx_in(rx_in), .err_rd(err_rd), .err_cnt(err_cnt), .locked(locked)
   );

   prbs_slot_engine #(.CNT_W(4)) dut_small (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .slot_idx(slot_idx),
      .mode(mode), .sel_slot(sel_slot), .tx_in(tx_in), .tx_out(tx_out_s),
      .rx_in(rx_in_s), .err_rd(err_rd), .err_cnt(err_cnt_s), .locked(locked_s)
   );

   // segment table: {mode[1:0], sel_slot[4:0], frames[2:0]}
   localparam int NSEG = 6;
   localparam logic [9:0] SEG [NSEG] = '{
      {2'b00, 5'd0,  3'd1},   // R1 whole frame
      {2'b01, 5'd0,  3'd2},   // R2 slot 0 kept
      {2'b10, 5'd5,  3'd3},   // R3 slot 5 only
      {2'b11, 5'd0,  3'd1},   // R4 off
      {2'b10, 5'd31, 3'd2},   // R3 last slot only
      {2'b00, 5'd0,  3'd1}    // R5 continuity after masked bits
   };

   function automatic logic is_active(input logic [1:0] m, input logic [4:0] sel,
                                      input logic [4:0] s);
      case (m)
         2'b00:   return 1'b1;
         2'b01:   return s != 5'd0;
         2'b10:   return s == sel;
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bit_en = 1'b0; err_rd = 1'b0; flip = 1'b0;
      mode = 2'b00; sel_slot = '0; slot_idx = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      g = '1; cur_slot = '0; cur_bit = '0;
   endtask

   // one bit: inputs set after a falling edge, tx_out compared to the model
   task automatic do_bit(input logic fl);
      logic act, expb;
      slot_idx = cur_slot;
      tx_in    = cur_slot[0] ^ cur_bit[1];
      bit_en   = 1'b1;
      flip     = fl;
      #1;
      act  = is_active(mode, sel_slot, cur_slot);
      expb = act ? ~(g[14] ^ g[13]) : tx_in;
      if (tx_out !== expb) seg_bad++;
      if (act) g = {g[13:0], g[14] ^ g[13]};
      @(negedge clk);
      bit_en = 1'b0;
      flip   = 1'b0;
      if (cur_bit == 3'd7) begin
         cur_bit  = '0;
         cur_slot = cur_slot + 1'b1;
      end else begin
         cur_bit = cur_bit + 1'b1;
      end
   endtask

   task automatic do_read();
      bit_en = 1'b0;
      err_rd = 1'b1;
      @(negedge clk);
      err_rd = 1'b0;
   endtask

   initial begin
      do_reset();
      // R6 R7 reset state
      check("R6 reset locked", 32'(locked), 32'd0);
      check("R7 reset err_cnt", 32'(err_cnt), 32'd0);

      // placement segments, looped back
      for (int k = 0; k < NSEG; k++) begin
         mode     = SEG[k][9:8];
         sel_slot = SEG[k][7:3];
         seg_bad  = 0;
         for (int b = 0; b < 256 * int'(SEG[k][2:0]); b++) do_bit(1'b0);
         case (SEG[k][9:8])
            2'b00:   check(k == 0 ? "R1 whole-frame pattern" : "R5 continuity", seg_bad, 0);
            2'b01:   check("R2 framed pattern", seg_bad, 0);
            2'b10:   check("R3 one-slot pattern", seg_bad, 0);
            default: check("R4 off passthrough", seg_bad, 0);
         endcase
      end
      check("R6 locked after clean stream", 32'(locked), 32'd1);
      check("R7 no errors counted", 32'(err_cnt), 32'd0);

      // R5 stall holds output and sequence
      mode = 2'b00;
      seg_bad = 0;
      for (int b = 0; b < 13; b++) do_bit(1'b0);
      begin
         logic held;
         slot_idx = cur_slot;
         #1 held = tx_out;
         repeat (5) @(negedge clk);
         check("R5 tx_out held in stall", 32'(tx_out), 32'(held));
      end
      for (int b = 0; b < 30; b++) do_bit(1'b0);
      check("R5 sequence continues after stall", seg_bad, 0);

      // R6 exact lock edge
      do_reset();
      for (int b = 0; b < 46; b++) do_bit(1'b0);
      check("R6 not locked after 46 bits", 32'(locked), 32'd0);
      do_bit(1'b0);
      check("R6 locked at 47th bit", 32'(locked), 32'd1);

      // R9 error during acquisition restarts fill
      do_reset();
      for (int b = 0; b < 20; b++) do_bit(1'b0);
      do_bit(1'b1);
      for (int b = 0; b < 46; b++) do_bit(1'b0);
      check("R9 lock delayed by refill", 32'(locked), 32'd0);
      do_bit(1'b0);
      check("R9 locked after refill", 32'(locked), 32'd1);

      // R7 counting and read-clear (first window after lock)
      for (int b = 0; b < 64; b++) do_bit(b == 10 || b == 30 || b == 50);
      check("R8 locked with 3 errors", 32'(locked), 32'd1);
      do_read();
      check("R7 count of 3, R9 acquisition error not counted", 32'(err_cnt), 32'd3);
      do_read();
      check("R7 count cleared by read", 32'(err_cnt), 32'd0);

      // R8 window threshold (new window)
      for (int b = 0; b < 5; b++) do_bit(1'b1);
      check("R8 locked after 5 errors", 32'(locked), 32'd1);
      do_bit(1'b1);
      check("R8 lock lost at 6th error", 32'(locked), 32'd0);
      do_read();
      check("R7 six errors counted", 32'(err_cnt), 32'd6);

      // R10 saturation on the narrow instance
      do_reset();
      for (int b = 0; b < 47; b++) do_bit(1'b0);
      for (int w = 0; w < 4; w++)
         for (int b = 0; b < 64; b++) do_bit(b < 5);
      check("R8 five per window keeps lock", 32'(locked), 32'd1);
      do_read();
      check("R7 twenty errors counted", 32'(err_cnt), 32'd20);
      check("R10 narrow counter saturates", 32'(err_cnt_s), 32'd15);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule